// File: doc/BRIEF.md
# Open-Drain Bus Port Register Controller

This block sits between a CPU register bus and seventeen open-drain lines of a parallel peripheral bus. Eight lines carry data. Nine lines carry control: reset, busy, select, attention, acknowledge, request, message, command/data and input/output. Software reads and writes eight byte-wide locations. Through them it sets a drive-low pattern for the data lines, picks the initiator or target role, chooses which control lines it pulls low, and reads back the live level of every line. Because of this, the port also works as general-purpose digital I/O.

Each line has a drive-low enable output and an input that reads 1 while the line is electrically low. The block gates every driver by role. In the initiator role it also gates the data drivers by whether the live bus phase matches the programmed phase bits. A busy line that drops while monitoring is enabled disables all drivers. A low reset line clears the registers. All line inputs pass through a two-flop synchronizer before any status read or phase comparison uses them.

Top module: `odbus_port_ctrl`

## Requirements
- R1: Writes at address 1 (stored bits 7 and 4..0), address 2 (all bits) and address 3 (bits 3..0) read back at the same address. After `rst`, every register reads 0 and no driver is enabled.
- R2: All lines are active low. A stored 1 enables a line's drive-low output, and a read of address 0 returns 1 for every data line that is low, whether or not the block drives it.
- R3: A write to address 0 only stores the byte. `data_drive` equals that byte while bit 0 of address 1 is 1 and its gating conditions hold, and is 0 otherwise.
- R4: `ctl_drive` index positions are: 0 I/O, 1 C/D, 2 MSG, 3 REQ, 4 SEL, 5 BSY, 6 ATN, 7 ACK, 8 RST. Address 2 bit 6 = 1 selects the target role. Address 1 bits 7, 3 and 2 drive RST, BSY and SEL in either role. Address 1 bits 4 and 1 drive ACK and ATN only in the initiator role. Address 3 bits 3..0 drive REQ, MSG, C/D and I/O only in the target role.
- R5: In the initiator role, data is driven only while the live I/O line is not low and the live MSG, C/D and I/O levels equal address 3 bits 2..0. That same equality is reported as address 5 bit 3.
- R6: Address 4 reads, from bit 7 down to bit 0: RST, BSY, REQ, MSG, C/D, I/O, SEL, and 0. Address 5 bit 1 is ATN, bit 0 is ACK, and bits 7..4 are 0.
- R7: While address 2 bit 2 is 1, a fall of the live BSY level sets address 5 bit 2. While that bit is set, every driver output is 0. The bit clears one clock after address 2 bit 2 reads 0.
- R8: A live low RST line clears all registers, the busy error and the latched byte, including when the block itself drives RST.
- R9: While address 2 bit 1 is 1, address 6 captures the live data lines on a rise of live ACK in the target role, or of live REQ in the initiator role. Otherwise address 6 holds its value.
- R10: A line change reaches status reads and phase comparison after exactly two clock edges.
- R11: Address 1 bits 6 and 5 always read 0. A write to address 4 changes no register and no driver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 3 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_rd | input | 1 | Read enable; `cpu_rdata` is 0 when low |
| cpu_rdata | output | 8 | Read data, combinational from address and state |
| data_low | input | 8 | 1 where a data line is electrically low |
| data_drive | output | 8 | Drive-low enables for the data lines |
| ctl_low | input | 9 | 1 where a control line is low (index map in R4) |
| ctl_drive | output | 9 | Drive-low enables for the control lines |

## Verification
A register write changes the driver outputs in the cycle right after the write edge. A line change shows up in reads and phase comparison after two edges. The busy error and reset clearing take effect one edge later than that, so three edges after the line moves. The reference model in the bench keeps its own two-stage history of the sampled lines and its own register images, updated on each rising edge. Every cycle it is compared against both driver outputs and the read data, at the falling edge, when all of those have settled. Directed checks wait out these latencies before sampling, and the latency test samples once before the second edge and once after it.

// File: rtl/odbp_pkg.sv
package odbp_pkg;
  localparam int DATA_W = 8;
  localparam int CTL_W  = 9;
  localparam int LINE_W = DATA_W + CTL_W;

  localparam int IDX_IO  = 0;
  localparam int IDX_CD  = 1;
  localparam int IDX_MSG = 2;
  localparam int IDX_REQ = 3;
  localparam int IDX_SEL = 4;
  localparam int IDX_BSY = 5;
  localparam int IDX_ATN = 6;
  localparam int IDX_ACK = 7;
  localparam int IDX_RST = 8;

  localparam int MODE_TGT = 6;
  localparam int MODE_MON = 2;
  localparam int MODE_DMA = 1;

  localparam logic [7:0] ICMD_KEEP = 8'h9F;

  typedef enum logic [2:0] {
    RA_DATA  = 3'd0,
    RA_ICMD  = 3'd1,
    RA_MODE  = 3'd2,
    RA_TCMD  = 3'd3,
    RA_STAT  = 3'd4,
    RA_BSTAT = 3'd5,
    RA_LATCH = 3'd6,
    RA_CLRP  = 3'd7
  } reg_addr_e;

  function automatic logic phase_eq(input logic [3:0] tcmd, input logic [2:0] live_ph);
    return tcmd[2:0] == live_ph;
  endfunction

  function automatic logic [7:0] stat_byte(input logic [CTL_W-1:0] c);
    return {c[IDX_RST], c[IDX_BSY], c[IDX_REQ], c[IDX_MSG],
            c[IDX_CD], c[IDX_IO], c[IDX_SEL], 1'b0};
  endfunction

  function automatic logic [7:0] bstat_byte(input logic pm, input logic berr,
                                            input logic atn, input logic ack);
    return {4'b0000, pm, berr, atn, ack};
  endfunction
endpackage

// File: rtl/odbp_sync.sv
module odbp_sync #(
  parameter int W      = 17,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/odbp_regs.sv
module odbp_regs
  import odbp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              bus_rst_s,
  input  logic              bsy_s,
  input  logic              ack_s,
  input  logic              req_s,
  input  logic [DATA_W-1:0] data_s,
  output logic [7:0]        data_q,
  output logic [7:0]        icmd_q,
  output logic [7:0]        mode_q,
  output logic [3:0]        tcmd_q,
  output logic              busy_err,
  output logic [7:0]        latch_q
);
  logic bsy_prev, ack_prev, req_prev;
  logic bsy_fall, cap_evt;

  assign bsy_fall = bsy_prev & ~bsy_s;
  assign cap_evt  = mode_q[MODE_DMA] &
                    (mode_q[MODE_TGT] ? (ack_s & ~ack_prev) : (req_s & ~req_prev));

  always_ff @(posedge clk) begin
    if (rst) begin
      bsy_prev <= 1'b0;
      ack_prev <= 1'b0;
      req_prev <= 1'b0;
    end else begin
      bsy_prev <= bsy_s;
      ack_prev <= ack_s;
      req_prev <= req_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || bus_rst_s) begin
      data_q   <= '0;
      icmd_q   <= '0;
      mode_q   <= '0;
      tcmd_q   <= '0;
      busy_err <= 1'b0;
      latch_q  <= '0;
    end else begin
      if (!mode_q[MODE_MON])  busy_err <= 1'b0;
      else if (bsy_fall)      busy_err <= 1'b1;
      if (cap_evt) latch_q <= data_s;
      if (wr_en) begin
        unique case (reg_addr_e'(wr_addr))
          RA_DATA: data_q <= wr_data;
          RA_ICMD: icmd_q <= wr_data & ICMD_KEEP;
          RA_MODE: mode_q <= wr_data;
          RA_TCMD: tcmd_q <= wr_data[3:0];
          default: ;
        endcase
      end
    end
  end

  AST_BUSRST_CLEARS: assert property (@(posedge clk) disable iff (rst)
    bus_rst_s |=> (data_q == '0 && icmd_q == '0 && mode_q == '0 && tcmd_q == '0 && !busy_err)); // R8
  AST_BUSY_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (mode_q[MODE_MON] && bsy_prev && !bsy_s && !bus_rst_s) |=> busy_err); // R7
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!cap_evt && !bus_rst_s) |=> $stable(latch_q)); // R9
endmodule

// File: rtl/odbp_drive.sv
module odbp_drive
  import odbp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        data_q,
  input  logic [7:0]        icmd_q,
  input  logic [7:0]        mode_q,
  input  logic [3:0]        tcmd_q,
  input  logic              busy_err,
  input  logic [2:0]        phase_s,
  output logic              phase_match,
  output logic [DATA_W-1:0] data_drive,
  output logic [CTL_W-1:0]  ctl_drive
);
  logic tgt, data_ok;
  logic [CTL_W-1:0] ctl_raw;

  always_comb begin
    tgt         = mode_q[MODE_TGT];
    phase_match = phase_eq(tcmd_q, phase_s);
    data_ok     = icmd_q[0] & ~busy_err & (tgt | (phase_match & ~phase_s[IDX_IO]));
    data_drive  = data_ok ? data_q : '0;

    ctl_raw          = '0;
    ctl_raw[IDX_RST] = icmd_q[7];
    ctl_raw[IDX_BSY] = icmd_q[3];
    ctl_raw[IDX_SEL] = icmd_q[2];
    ctl_raw[IDX_ACK] = icmd_q[4] & ~tgt;
    ctl_raw[IDX_ATN] = icmd_q[1] & ~tgt;
    ctl_raw[IDX_REQ] = tcmd_q[3] & tgt;
    ctl_raw[IDX_MSG] = tcmd_q[2] & tgt;
    ctl_raw[IDX_CD]  = tcmd_q[1] & tgt;
    ctl_raw[IDX_IO]  = tcmd_q[0] & tgt;
    ctl_drive        = busy_err ? '0 : ctl_raw;
  end

  AST_DATA_NEEDS_ASSERT: assert property (@(posedge clk) disable iff (rst)
    (|data_drive) |-> icmd_q[0]); // R3
  AST_ATN_ACK_INIT_ONLY: assert property (@(posedge clk) disable iff (rst)
    (ctl_drive[IDX_ACK] || ctl_drive[IDX_ATN]) |-> !mode_q[MODE_TGT]); // R4
  AST_PHASE_TGT_ONLY: assert property (@(posedge clk) disable iff (rst)
    (|ctl_drive[3:0]) |-> mode_q[MODE_TGT]); // R4
  AST_INIT_DATA_PHASE: assert property (@(posedge clk) disable iff (rst)
    (!mode_q[MODE_TGT] && (|data_drive)) |-> (!phase_s[IDX_IO] && phase_s == tcmd_q[2:0])); // R5
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
    busy_err |-> (data_drive == '0 && ctl_drive == '0)); // R7
endmodule

// File: rtl/odbus_port_ctrl.sv
module odbus_port_ctrl
  import odbp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  output logic [7:0]        cpu_rdata,
  input  logic [DATA_W-1:0] data_low,
  output logic [DATA_W-1:0] data_drive,
  input  logic [CTL_W-1:0]  ctl_low,
  output logic [CTL_W-1:0]  ctl_drive
);
  logic [LINE_W-1:0] lines_s;
  logic [DATA_W-1:0] data_s;
  logic [CTL_W-1:0]  ctl_s;
  logic [7:0] data_q, icmd_q, mode_q, latch_q;
  logic [3:0] tcmd_q;
  logic busy_err, phase_match;
  logic [7:0] rd_mux;

  odbp_sync #(.W(LINE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({ctl_low, data_low}), .q(lines_s)
  );

  assign data_s = lines_s[DATA_W-1:0];
  assign ctl_s  = lines_s[LINE_W-1:DATA_W];

  odbp_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(cpu_wr), .wr_addr(cpu_addr), .wr_data(cpu_wdata),
    .bus_rst_s(ctl_s[IDX_RST]), .bsy_s(ctl_s[IDX_BSY]), .ack_s(ctl_s[IDX_ACK]),
    .req_s(ctl_s[IDX_REQ]), .data_s(data_s),
    .data_q(data_q), .icmd_q(icmd_q), .mode_q(mode_q), .tcmd_q(tcmd_q),
    .busy_err(busy_err), .latch_q(latch_q)
  );

  odbp_drive u_drive (
    .clk(clk), .rst(rst), .data_q(data_q), .icmd_q(icmd_q), .mode_q(mode_q),
    .tcmd_q(tcmd_q), .busy_err(busy_err), .phase_s(ctl_s[2:0]),
    .phase_match(phase_match), .data_drive(data_drive), .ctl_drive(ctl_drive)
  );

  always_comb begin
    unique case (reg_addr_e'(cpu_addr))
      RA_DATA:  rd_mux = data_s;
      RA_ICMD:  rd_mux = icmd_q;
      RA_MODE:  rd_mux = mode_q;
      RA_TCMD:  rd_mux = {4'b0000, tcmd_q};
      RA_STAT:  rd_mux = stat_byte(ctl_s);
      RA_BSTAT: rd_mux = bstat_byte(phase_match, busy_err, ctl_s[IDX_ATN], ctl_s[IDX_ACK]);
      RA_LATCH: rd_mux = latch_q;
      default:  rd_mux = 8'h00;
    endcase
    cpu_rdata = cpu_rd ? rd_mux : 8'h00;
  end

  AST_ICMD_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr == 3'd1) |-> (cpu_rdata[6:5] == 2'b00)); // R11
endmodule

// File: tb/odbus_port_ctrl_test.sv
module odbus_port_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] cpu_addr = 3'd0;
  logic [7:0] cpu_wdata = 8'h00;
  logic cpu_wr = 1'b0;
  logic cpu_rd = 1'b1;
  logic [7:0] cpu_rdata;
  logic [7:0] data_drive, ext_d = 8'h00;
  logic [8:0] ctl_drive, ext_c = 9'h000;
  wire  [7:0] data_low = data_drive | ext_d;
  wire  [8:0] ctl_low  = ctl_drive | ext_c;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  odbus_port_ctrl uut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
    .data_low(data_low), .data_drive(data_drive),
    .ctl_low(ctl_low), .ctl_drive(ctl_drive)
  );

  // reference model state
  logic [16:0] m_h1 = '0, m_h2 = '0, smp_lines = '0;
  logic m_bp = 0, m_ap = 0, m_rp = 0, m_busy = 0;
  logic [7:0] m_data = 0, m_icr = 0, m_mode = 0, m_latch = 0, smp_wd = 0;
  logic [3:0] m_tcr = 0;
  logic smp_wr = 0;
  logic [2:0] smp_a = 0;

  function automatic logic live(input int idx);
    return m_h2[8 + idx];
  endfunction

  function automatic logic m_pm();
    return (live(2) == m_tcr[2]) && (live(1) == m_tcr[1]) && (live(0) == m_tcr[0]);
  endfunction

  function automatic logic [8:0] exp_ctl();
    logic [8:0] v;
    v = 9'h000;
    if (m_busy) return v;
    if (m_icr[7]) v = v | 9'h100;
    if (m_icr[3]) v = v | 9'h020;
    if (m_icr[2]) v = v | 9'h010;
    if (!m_mode[6]) begin
      if (m_icr[4]) v = v | 9'h080;
      if (m_icr[1]) v = v | 9'h040;
    end else begin
      v = v | {5'b0, m_tcr};
    end
    return v;
  endfunction

  function automatic logic [7:0] exp_data();
    if (!m_icr[0] || m_busy) return 8'h00;
    if (m_mode[6]) return m_data;
    if (m_pm() && !live(0)) return m_data;
    return 8'h00;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_h2[7:0];
      3'd1: return m_icr;
      3'd2: return m_mode;
      3'd3: return {4'h0, m_tcr};
      3'd4: return {live(8), live(5), live(3), live(2), live(1), live(0), live(4), 1'b0};
      3'd5: return {4'h0, m_pm(), m_busy, live(6), live(7)};
      3'd6: return m_latch;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_h1 = '0; m_h2 = '0; m_bp = 0; m_ap = 0; m_rp = 0;
      m_data = 0; m_icr = 0; m_mode = 0; m_tcr = 0; m_busy = 0; m_latch = 0;
    end else begin
      if (live(8)) begin
        m_data = 0; m_icr = 0; m_mode = 0; m_tcr = 0; m_busy = 0; m_latch = 0;
      end else begin
        if (!m_mode[2]) m_busy = 0;
        else if (m_bp && !live(5)) m_busy = 1;
        if (m_mode[1] && (m_mode[6] ? (live(7) && !m_ap) : (live(3) && !m_rp)))
          m_latch = m_h2[7:0];
        if (smp_wr) begin
          case (smp_a)
            3'd0: m_data = smp_wd;
            3'd1: m_icr = smp_wd & 8'h9F;
            3'd2: m_mode = smp_wd;
            3'd3: m_tcr = smp_wd[3:0];
            default: ;
          endcase
        end
      end
      m_bp = live(5); m_ap = live(7); m_rp = live(3);
      m_h2 = m_h1;
      m_h1 = smp_lines;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (data_drive !== exp_data()) begin
        errors++;
        $display("FAIL R3 data_drive actual %h expected %h", data_drive, exp_data());
      end
      checks++;
      if (ctl_drive !== exp_ctl()) begin
        errors++;
        $display("FAIL R4 ctl_drive actual %h expected %h", ctl_drive, exp_ctl());
      end
      checks++;
      if (cpu_rdata !== exp_rd(cpu_addr)) begin
        errors++;
        $display("FAIL R1 rdata@%0d actual %h expected %h", cpu_addr, cpu_rdata, exp_rd(cpu_addr));
      end
    end
    smp_lines = {ctl_low, data_low};
    smp_wr = cpu_wr;
    smp_a = cpu_addr;
    smp_wd = cpu_wdata;
  end

  always @(posedge clk) begin
    if (cyc >= 50000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL R1 watchdog actual %0d cycles expected fewer", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(posedge clk); #1;
    cpu_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
    @(posedge clk); #1;
    cpu_addr = a;
    @(negedge clk);
    chk(tag, {8'h00, cpu_rdata}, {8'h00, exp});
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    settle(3);
    rst = 1'b0;
    // R1 reset state
    rd_chk("R1 reset icmd", 3'd1, 8'h00);
    rd_chk("R1 reset mode", 3'd2, 8'h00);
    rd_chk("R1 reset tcmd", 3'd3, 8'h00);
    @(negedge clk);
    chk("R1 reset drivers", {data_drive, 8'h00}, 16'h0000);
    // R4 target role phase lines
    wr(3'd2, 8'h40);
    wr(3'd3, 8'h0A);
    @(negedge clk);
    chk("R4 target tcmd drive", {7'h0, ctl_drive}, 16'h000A);
    rd_chk("R1 tcmd readback", 3'd3, 8'h0A);
    // R3 data stored but not driven
    wr(3'd0, 8'h5A);
    @(negedge clk);
    chk("R3 no drive before assert", {8'h00, data_drive}, 16'h0000);
    wr(3'd1, 8'h01);
    @(negedge clk);
    chk("R3 drive after assert", {8'h00, data_drive}, 16'h005A);
    settle(3);
    rd_chk("R2 live data read", 3'd0, 8'h5A);
    // R10 two-edge latency
    @(posedge clk); #1;
    ext_d = 8'h81;
    @(negedge clk);
    chk("R10 before first edge", {8'h00, cpu_rdata}, 16'h005A);
    @(negedge clk);
    chk("R10 after one edge", {8'h00, cpu_rdata}, 16'h005A);
    @(negedge clk);
    chk("R10 after two edges", {8'h00, cpu_rdata}, 16'h00DB);
    @(posedge clk); #1;
    ext_d = 8'h00;
    // R11 / R4 command bits in target role
    wr(3'd1, 8'h7F);
    @(negedge clk);
    chk("R4 target ctl drive", {7'h0, ctl_drive}, 16'h003A);
    rd_chk("R11 icmd spare bits", 3'd1, 8'h1F);
    // R5 initiator role phase gating
    wr(3'd2, 8'h00);
    settle(4);
    @(negedge clk);
    chk("R4 initiator ctl drive", {7'h0, ctl_drive}, 16'h00F0);
    chk("R5 mismatch no data", {8'h00, data_drive}, 16'h0000);
    rd_chk("R6 bstat no match", 3'd5, 8'h03);
    @(posedge clk); #1;
    ext_c = 9'h002;
    settle(3);
    @(negedge clk);
    chk("R5 match drives data", {8'h00, data_drive}, 16'h005A);
    rd_chk("R5 phase match flag", 3'd5, 8'h0B);
    rd_chk("R6 bus status", 3'd4, 8'h4A);
    wr(3'd3, 8'h03);
    @(posedge clk); #1;
    ext_c = 9'h003;
    settle(3);
    @(negedge clk);
    chk("R5 io low blocks data", {8'h00, data_drive}, 16'h0000);
    rd_chk("R5 match with io", 3'd5, 8'h0B);
    // R7 busy error
    wr(3'd2, 8'h04);
    wr(3'd1, 8'h17);
    settle(4);
    @(negedge clk);
    chk("R7 drivers off", {7'h0, ctl_drive}, 16'h0000);
    rd_chk("R7 busy flag", 3'd5, 8'h0C);
    wr(3'd2, 8'h00);
    settle(3);
    @(negedge clk);
    chk("R7 busy cleared", {7'h0, ctl_drive}, 16'h00D0);
    // R9 latch
    wr(3'd1, 8'h00);
    @(posedge clk); #1;
    ext_c = 9'h000; ext_d = 8'h3C;
    wr(3'd2, 8'h42);
    settle(3);
    @(posedge clk); #1;
    ext_c = 9'h080;
    settle(4);
    rd_chk("R9 captured on ack", 3'd6, 8'h3C);
    @(posedge clk); #1;
    ext_d = 8'h11;
    settle(4);
    rd_chk("R9 held without edge", 3'd6, 8'h3C);
    rd_chk("R2 live data", 3'd0, 8'h11);
    @(posedge clk); #1;
    ext_c = 9'h000; ext_d = 8'h00;
    // R11 select-enable write ignored
    wr(3'd4, 8'hFF);
    rd_chk("R11 mode kept", 3'd2, 8'h42);
    rd_chk("R11 tcmd kept", 3'd3, 8'h03);
    rd_chk("R11 icmd kept", 3'd1, 8'h00);
    // R8 bus reset
    @(posedge clk); #1;
    ext_c = 9'h100;
    settle(4);
    rd_chk("R8 mode cleared", 3'd2, 8'h00);
    rd_chk("R8 latch cleared", 3'd6, 8'h00);
    @(posedge clk); #1;
    ext_c = 9'h000;
    settle(3);
    wr(3'd2, 8'h40);
    wr(3'd1, 8'h80);
    @(negedge clk);
    chk("R8 self rst drive", {7'h0, ctl_drive}, 16'h0100);
    settle(5);
    @(negedge clk);
    chk("R8 self rst cleared", {7'h0, ctl_drive}, 16'h0000);
    rd_chk("R8 self rst mode", 3'd2, 8'h00);
    settle(4);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule